// File: doc/BRIEF.md
# Mesh XY Path Reservation Unit

This block sets up routes on a two-dimensional router mesh that uses fixed dimension-ordered routing. A requester presents a tag with a source and a destination router coordinate. The block computes the horizontal leg and the vertical leg of the route. It then waits until it can take exclusive ownership of the directed row and column resources that those legs occupy. Once the whole route is held, it issues a grant that carries the tag and the hop count, so the caller can charge a fixed delay per hop. A later release naming the same tag frees every resource recorded for that tag.

A request that cannot be granted at once waits in a small queue kept in arrival order. On every cycle the oldest waiting request whose resources are all free is granted. A blocked request at the head therefore does not hold back younger requests that need other resources. Coordinates that fall outside the grid, or inside the excluded centre block where no routers exist, are rejected with an error pulse.

Top module: `mesh_xy_resv`

## Requirements
- R1: A route runs along the source row from the source column to the destination column, then along the destination column from the source row to the destination row; `gnt_hops` equals |dst_col-src_col| + |dst_row-src_row|.
- R2: The owned resource is one row or one column together with a travel direction (toward higher or toward lower coordinates). Legs on the same row, or on the same column, contend only when they travel the same way; a leg travelling the opposite way is granted even while the first is held.
- R3: Each directed resource has at most one owning tag at any time. A request that needs a held resource is not granted until that resource is released.
- R4: A request claims all of its resources in the cycle it is granted, and it holds none of them while it waits, so a waiting request never blocks a third request that needs only the resources it is still waiting for.
- R5: A leg of zero length claims nothing. A request whose source equals its destination is granted with `gnt_hops` = 0 and holds no resource.
- R6: Among the queued requests that are eligible on a cycle, the one that arrived first is granted. An older blocked request does not delay a younger eligible one.
- R7: A coordinate with row >= 6 or column >= 6, or with row in 2..3 and column in 2..3, makes the request invalid. One cycle later `rej_valid` pulses with the tag. The request is never queued and never granted.
- R8: A release frees exactly the resources recorded for its tag. A request waiting on those resources can be granted on the same clock edge that applies the release.
- R9: A request accepted on a clock edge is granted on the next edge at the earliest, and `gnt_valid` is a single-cycle pulse. `req_ready` is low while the queue holds 4 entries, and a request offered while it is low is ignored.
- R10: After reset `gnt_valid` and `rej_valid` are low, `req_ready` is high and every resource is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Route request present |
| req_ready | output | 1 | Queue can take a request this cycle |
| req_tag | input | 4 | Transaction tag of the request |
| req_src_row | input | 3 | Source router row |
| req_src_col | input | 3 | Source router column |
| req_dst_row | input | 3 | Destination router row |
| req_dst_col | input | 3 | Destination router column |
| rel_valid | input | 1 | Release the resources owned by `rel_tag` |
| rel_tag | input | 4 | Tag to release |
| gnt_valid | output | 1 | Route granted (one-cycle pulse) |
| gnt_tag | output | 4 | Tag of the granted route |
| gnt_hops | output | 4 | Manhattan hop count of the granted route |
| rej_valid | output | 1 | Request rejected for an invalid coordinate |
| rej_tag | output | 4 | Tag of the rejected request |

## Verification
A release and a grant of the request waiting on the freed resource can fall on the same clock edge. The bench provokes this by holding a row with one tag, queueing a second request on that row, and then releasing the first tag. It expects the waiter's grant to appear right after that very edge, not one cycle later. It also fills the queue behind a held row and releases the tags one at a time, which checks that the order of grants follows the order of arrival.

// File: rtl/mxr_pkg.sv
package mxr_pkg;

    // Widest coordinate the route logic carries internally.
    localparam int unsigned MXR_CW = 4;

    // Travel direction of one leg along its band.
    typedef enum logic {
        DIR_UP   = 1'b0,   // toward higher coordinate
        DIR_DOWN = 1'b1    // toward lower coordinate
    } leg_dir_e;

    // One leg of a dimension-ordered route.
    typedef struct packed {
        logic              need;   // leg has non-zero length
        logic              horiz;  // 1: along a row, 0: along a column
        logic [MXR_CW-1:0] band;   // row or column index
        logic [MXR_CW-1:0] lo;
        logic [MXR_CW-1:0] hi;
        leg_dir_e          dir;
    } leg_t;

    function automatic logic [MXR_CW-1:0] coord_min(input logic [MXR_CW-1:0] a,
                                                    input logic [MXR_CW-1:0] b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic [MXR_CW-1:0] coord_max(input logic [MXR_CW-1:0] a,
                                                    input logic [MXR_CW-1:0] b);
        return (a < b) ? b : a;
    endfunction

endpackage

// File: rtl/mxr_route.sv
module mxr_route
    import mxr_pkg::*;
#(
    parameter int ROWS  = 6,
    parameter int COLS  = 6,
    parameter int CW    = 3,
    parameter int ZR0   = 2,
    parameter int ZR1   = 3,
    parameter int ZC0   = 2,
    parameter int ZC1   = 3,
    parameter int NRES  = 24,
    parameter int HOP_W = 4
) (
    input  logic [CW-1:0]    src_row,
    input  logic [CW-1:0]    src_col,
    input  logic [CW-1:0]    dst_row,
    input  logic [CW-1:0]    dst_col,
    output logic             bad,
    output logic [NRES-1:0]  mask,
    output logic [HOP_W-1:0] hops
);

    leg_t leg_h;
    leg_t leg_v;
    logic [MXR_CW-1:0] sr, sc, dr, dc;

    function automatic logic on_mesh(input logic [CW-1:0] r, input logic [CW-1:0] c);
        logic in_rng;
        logic in_zone;
        in_rng  = (int'(r) < ROWS) && (int'(c) < COLS);
        in_zone = (int'(r) >= ZR0) && (int'(r) <= ZR1) &&
                  (int'(c) >= ZC0) && (int'(c) <= ZC1);
        return in_rng && !in_zone;
    endfunction

    always_comb begin
        sr = MXR_CW'(src_row);
        sc = MXR_CW'(src_col);
        dr = MXR_CW'(dst_row);
        dc = MXR_CW'(dst_col);

        bad = !on_mesh(src_row, src_col) || !on_mesh(dst_row, dst_col);

        // first leg: along the source row
        leg_h.need  = (sc != dc);
        leg_h.horiz = 1'b1;
        leg_h.band  = sr;
        leg_h.lo    = coord_min(sc, dc);
        leg_h.hi    = coord_max(sc, dc);
        leg_h.dir   = (dc > sc) ? DIR_UP : DIR_DOWN;

        // second leg: along the destination column
        leg_v.need  = (sr != dr);
        leg_v.horiz = 1'b0;
        leg_v.band  = dc;
        leg_v.lo    = coord_min(sr, dr);
        leg_v.hi    = coord_max(sr, dr);
        leg_v.dir   = (dr > sr) ? DIR_UP : DIR_DOWN;

        hops = HOP_W'(leg_h.hi - leg_h.lo) + HOP_W'(leg_v.hi - leg_v.lo);
    end

    // resource index: rows first (2 per row), then columns (2 per column)
    for (genvar r = 0; r < ROWS; r++) begin : g_row_res
        assign mask[2*r]   = leg_h.need && leg_h.horiz && (int'(leg_h.band) == r) &&
                             (leg_h.dir == DIR_UP);
        assign mask[2*r+1] = leg_h.need && leg_h.horiz && (int'(leg_h.band) == r) &&
                             (leg_h.dir == DIR_DOWN);
    end

    for (genvar c = 0; c < COLS; c++) begin : g_col_res
        assign mask[2*ROWS+2*c]   = leg_v.need && !leg_v.horiz && (int'(leg_v.band) == c) &&
                                    (leg_v.dir == DIR_UP);
        assign mask[2*ROWS+2*c+1] = leg_v.need && !leg_v.horiz && (int'(leg_v.band) == c) &&
                                    (leg_v.dir == DIR_DOWN);
    end

endmodule

// File: rtl/mxr_pick.sv
module mxr_pick #(
    parameter int QD   = 4,
    parameter int QI_W = 2
) (
    input  logic [QD-1:0]   elig,
    output logic            pick_v,
    output logic [QI_W-1:0] pick_idx
);

    // lowest index is the oldest entry
    always_comb begin
        pick_v   = 1'b0;
        pick_idx = '0;
        for (int i = QD - 1; i >= 0; i--) begin
            if (elig[i]) begin
                pick_v   = 1'b1;
                pick_idx = QI_W'(i);
            end
        end
    end

endmodule

// File: rtl/mesh_xy_resv.sv
module mesh_xy_resv
    import mxr_pkg::*;
#(
    parameter int ROWS  = 6,
    parameter int COLS  = 6,
    parameter int ZR0   = 2,
    parameter int ZR1   = 3,
    parameter int ZC0   = 2,
    parameter int ZC1   = 3,
    parameter int TAG_W = 4,
    parameter int QD    = 4
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      req_valid,
    output logic                                      req_ready,
    input  logic [TAG_W-1:0]                          req_tag,
    input  logic [$clog2((ROWS > COLS) ? ROWS : COLS)-1:0] req_src_row,
    input  logic [$clog2((ROWS > COLS) ? ROWS : COLS)-1:0] req_src_col,
    input  logic [$clog2((ROWS > COLS) ? ROWS : COLS)-1:0] req_dst_row,
    input  logic [$clog2((ROWS > COLS) ? ROWS : COLS)-1:0] req_dst_col,
    input  logic                                      rel_valid,
    input  logic [TAG_W-1:0]                          rel_tag,
    output logic                                      gnt_valid,
    output logic [TAG_W-1:0]                          gnt_tag,
    output logic [$clog2(ROWS + COLS)-1:0]            gnt_hops,
    output logic                                      rej_valid,
    output logic [TAG_W-1:0]                          rej_tag
);

    localparam int CW    = $clog2((ROWS > COLS) ? ROWS : COLS);
    localparam int NRES  = 2 * (ROWS + COLS);
    localparam int NTAG  = 1 << TAG_W;
    localparam int HOP_W = $clog2(ROWS + COLS);
    localparam int QI_W  = $clog2(QD);
    localparam int CNT_W = $clog2(QD + 1);

    typedef struct packed {
        logic [CNT_W-1:0]            cnt;
        logic [QD-1:0][TAG_W-1:0]    qtag;
        logic [QD-1:0][NRES-1:0]     qmask;
        logic [QD-1:0][HOP_W-1:0]    qhops;
        logic [NRES-1:0]             busy;
        logic [NTAG-1:0][NRES-1:0]   held;
        logic                        gv;
        logic [TAG_W-1:0]            gtag;
        logic [HOP_W-1:0]            ghops;
        logic                        rv;
        logic [TAG_W-1:0]            rtag;
    } st_t;

    st_t s_d, s_q;

    logic             new_bad;
    logic [NRES-1:0]  new_mask;
    logic [HOP_W-1:0] new_hops;
    logic [NRES-1:0]  rel_mask;
    logic [NRES-1:0]  free_view;
    logic [QD-1:0]    elig;
    logic             pick_v;
    logic [QI_W-1:0]  pick_idx;

    mxr_route #(
        .ROWS(ROWS), .COLS(COLS), .CW(CW),
        .ZR0(ZR0), .ZR1(ZR1), .ZC0(ZC0), .ZC1(ZC1),
        .NRES(NRES), .HOP_W(HOP_W)
    ) route_i (
        .src_row (req_src_row),
        .src_col (req_src_col),
        .dst_row (req_dst_row),
        .dst_col (req_dst_col),
        .bad     (new_bad),
        .mask    (new_mask),
        .hops    (new_hops)
    );

    // release is applied before eligibility, so a freed resource is usable at once
    always_comb begin
        rel_mask  = rel_valid ? s_q.held[rel_tag] : '0;
        free_view = s_q.busy & ~rel_mask;
        for (int i = 0; i < QD; i++) begin
            elig[i] = (i < int'(s_q.cnt)) && ((s_q.qmask[i] & free_view) == '0);
        end
    end

    mxr_pick #(.QD(QD), .QI_W(QI_W)) pick_i (
        .elig     (elig),
        .pick_v   (pick_v),
        .pick_idx (pick_idx)
    );

    assign req_ready = int'(s_q.cnt) < QD;

    always_comb begin
        logic [CNT_W-1:0] cnt_n;

        s_d      = s_q;
        s_d.gv   = 1'b0;
        s_d.rv   = 1'b0;
        s_d.busy = free_view;
        if (rel_valid) begin
            s_d.held[rel_tag] = '0;
        end
        cnt_n = s_q.cnt;

        if (pick_v) begin
            s_d.busy                        = free_view | s_q.qmask[pick_idx];
            s_d.held[s_q.qtag[pick_idx]]    = s_q.qmask[pick_idx];
            s_d.gv                          = 1'b1;
            s_d.gtag                        = s_q.qtag[pick_idx];
            s_d.ghops                       = s_q.qhops[pick_idx];
            for (int i = 0; i < QD - 1; i++) begin
                if (i >= int'(pick_idx)) begin
                    s_d.qtag[i]  = s_q.qtag[i+1];
                    s_d.qmask[i] = s_q.qmask[i+1];
                    s_d.qhops[i] = s_q.qhops[i+1];
                end
            end
            cnt_n = s_q.cnt - 1'b1;
        end

        if (req_valid && req_ready) begin
            if (new_bad) begin
                s_d.rv   = 1'b1;
                s_d.rtag = req_tag;
            end else begin
                s_d.qtag[QI_W'(cnt_n)]  = req_tag;
                s_d.qmask[QI_W'(cnt_n)] = new_mask;
                s_d.qhops[QI_W'(cnt_n)] = new_hops;
                cnt_n = cnt_n + 1'b1;
            end
        end

        s_d.cnt = cnt_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign gnt_valid = s_q.gv;
    assign gnt_tag   = s_q.gtag;
    assign gnt_hops  = s_q.ghops;
    assign rej_valid = s_q.rv;
    assign rej_tag   = s_q.rtag;

endmodule

// File: rtl/mxr_chk.sv
module mxr_chk #(
    parameter int NRES  = 24,
    parameter int NTAG  = 16,
    parameter int TAG_W = 4,
    parameter int HOP_W = 4,
    parameter int CNT_W = 3,
    parameter int QD    = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          rel_valid,
    input logic [TAG_W-1:0]              rel_tag,
    input logic                          gnt_valid,
    input logic [TAG_W-1:0]              gnt_tag,
    input logic [HOP_W-1:0]              gnt_hops,
    input logic [CNT_W-1:0]              cnt,
    input logic [NRES-1:0]               busy,
    input logic [NTAG-1:0][NRES-1:0]     held
);

    logic [NRES-1:0] held_any;

    always_comb begin
        held_any = '0;
        for (int t = 0; t < NTAG; t++) begin
            held_any = held_any | held[t];
        end
    end

    for (genvar r = 0; r < NRES; r++) begin : g_owner
        logic [NTAG-1:0] owners;
        always_comb begin
            for (int t = 0; t < NTAG; t++) begin
                owners[t] = held[t][r];
            end
        end
        AST_SEG_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(owners)); // R3
    end

    AST_BUSY_MATCHES_OWNERS: assert property (@(posedge clk) disable iff (!rst_n)
        busy == held_any); // R8

    AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) <= QD); // R9

    AST_ZERO_HOP_NO_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && gnt_hops == '0) |-> (held[gnt_tag] == '0)); // R5

    AST_GRANT_HOLDS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && gnt_hops != '0) |-> (held[gnt_tag] != '0)); // R4

    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |=> ((gnt_valid && gnt_tag == $past(rel_tag)) ||
                       (held[$past(rel_tag)] == '0))); // R8

endmodule

bind mesh_xy_resv mxr_chk #(
    .NRES(NRES), .NTAG(NTAG), .TAG_W(TAG_W),
    .HOP_W(HOP_W), .CNT_W(CNT_W), .QD(QD)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rel_valid (rel_valid),
    .rel_tag   (rel_tag),
    .gnt_valid (gnt_valid),
    .gnt_tag   (gnt_tag),
    .gnt_hops  (gnt_hops),
    .cnt       (s_q.cnt),
    .busy      (s_q.busy),
    .held      (s_q.held)
);

// File: tb/mesh_xy_resv_tb_top.sv
module mesh_xy_resv_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [3:0] req_tag = '0;
    logic [2:0] req_src_row = '0;
    logic [2:0] req_src_col = '0;
    logic [2:0] req_dst_row = '0;
    logic [2:0] req_dst_col = '0;
    logic       rel_valid = 1'b0;
    logic [3:0] rel_tag = '0;
    logic       gnt_valid;
    logic [3:0] gnt_tag;
    logic [3:0] gnt_hops;
    logic       rej_valid;
    logic [3:0] rej_tag;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    mesh_xy_resv dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_tag(req_tag),
        .req_src_row(req_src_row), .req_src_col(req_src_col),
        .req_dst_row(req_dst_row), .req_dst_col(req_dst_col),
        .rel_valid(rel_valid), .rel_tag(rel_tag),
        .gnt_valid(gnt_valid), .gnt_tag(gnt_tag), .gnt_hops(gnt_hops),
        .rej_valid(rej_valid), .rej_tag(rej_tag)
    );

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic drive_req(input int tag, input int sr, input int sc, input int dr, input int dc);
        req_valid   = 1'b1;
        req_tag     = 4'(tag);
        req_src_row = 3'(sr);
        req_src_col = 3'(sc);
        req_dst_row = 3'(dr);
        req_dst_col = 3'(dc);
        @(negedge clk);
        req_valid   = 1'b0;
    endtask

    task automatic drive_rel(input int tag);
        rel_valid = 1'b1;
        rel_tag   = 4'(tag);
        @(negedge clk);
        rel_valid = 1'b0;
    endtask

    task automatic expect_gnt(input string req, input int tag, input int hops);
        check_eq(req, "gnt_valid", int'(gnt_valid), 1);
        if (gnt_valid) begin
            check_eq(req, "gnt_tag", int'(gnt_tag), tag);
            check_eq(req, "gnt_hops", int'(gnt_hops), hops);
        end
    endtask

    task automatic expect_idle(input string req);
        check_eq(req, "gnt_valid", int'(gnt_valid), 0);
    endtask

    function automatic bit valid_rc(input int r, input int c);
        return (r < 6) && (c < 6) && !((r >= 2) && (r <= 3) && (c >= 2) && (c <= 3));
    endfunction

    function automatic int absd(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();

        // R10: reset state
        check_eq("R10", "gnt_valid", int'(gnt_valid), 0);
        check_eq("R10", "rej_valid", int'(rej_valid), 0);
        check_eq("R10", "req_ready", int'(req_ready), 1);

        // R3/R2/R5/R8: contention on row 0
        drive_req(1, 0, 0, 0, 5);
        expect_idle("R9 no grant on accept edge");
        tick();
        expect_gnt("R1", 1, 5);
        tick();
        expect_idle("R9 single pulse");

        drive_req(2, 0, 1, 0, 4);          // same row, same direction
        tick();
        tick();
        expect_idle("R3 blocked by owner");

        drive_req(3, 0, 5, 0, 0);          // same row, opposite direction
        tick();
        expect_gnt("R2 opposite direction", 3, 5);

        drive_req(4, 0, 0, 3, 0);          // column only, no row leg
        tick();
        expect_gnt("R5 zero-length row leg", 4, 3);

        drive_rel(1);                      // waiter granted on the release edge
        expect_gnt("R8 same-edge release grant", 2, 3);
        drive_rel(2);
        expect_idle("R8 nothing waiting");
        drive_rel(3);
        drive_rel(4);

        // R4/R6: blocked request holds nothing, younger requests pass it
        drive_req(1, 0, 0, 0, 5);
        tick();
        expect_gnt("R1", 1, 5);
        drive_req(5, 0, 0, 5, 5);          // row 0 up + column 5 up
        tick();
        expect_idle("R3 row held");
        drive_req(6, 5, 0, 5, 5);
        tick();
        expect_gnt("R6 younger passes blocked head", 6, 5);
        drive_req(7, 1, 5, 4, 5);          // column 5 up, wanted by tag 5 too
        tick();
        expect_gnt("R4 waiter holds no partial route", 7, 3);
        drive_rel(7);
        expect_idle("R4 still blocked on row");
        drive_rel(6);
        expect_idle("R4 still blocked on row");
        drive_rel(1);
        expect_gnt("R8 release unblocks full route", 5, 10);
        drive_rel(5);

        // R9/R6: fill the queue behind a held row
        drive_req(1, 0, 0, 0, 5);
        tick();
        expect_gnt("R1", 1, 5);
        for (int k = 1; k <= 4; k++) begin
            drive_req(7 + k, 0, 0, 0, k);
        end
        check_eq("R9", "req_ready when full", int'(req_ready), 0);
        drive_req(12, 1, 0, 1, 0);         // offered while not ready
        tick();
        expect_idle("R9 ignored while full");
        check_eq("R9", "rej_valid while full", int'(rej_valid), 0);
        drive_rel(1);
        expect_gnt("R6 oldest first", 8, 1);
        check_eq("R9", "req_ready after grant", int'(req_ready), 1);
        for (int k = 2; k <= 4; k++) begin
            drive_rel(6 + k);
            expect_gnt("R6 arrival order", 7 + k, k);
        end
        drive_rel(11);
        expect_idle("R9 ignored request never granted");

        // R1/R5/R7: exhaustive sweep of every coordinate pair
        for (int s = 0; s < 64; s++) begin
            for (int d = 0; d < 64; d++) begin
                int sr = s / 8;
                int sc = s % 8;
                int dr = d / 8;
                int dc = d % 8;
                int tag = (s + d) % 16;
                bit ok = valid_rc(sr, sc) && valid_rc(dr, dc);
                drive_req(tag, sr, sc, dr, dc);
                if (!ok) begin
                    check_eq("R7", "rej_valid", int'(rej_valid), 1);
                    check_eq("R7", "rej_tag", int'(rej_tag), tag);
                    tick();
                    expect_idle("R7 rejected never granted");
                end else begin
                    check_eq("R7", "rej_valid on valid", int'(rej_valid), 0);
                    expect_idle("R9 no grant on accept edge");
                    tick();
                    expect_gnt((sr == dr && sc == dc) ? "R5 zero hop" : "R1 sweep",
                               tag, absd(sc, dc) + absd(sr, dr));
                    drive_rel(tag);
                end
            end
        end

        // R8: everything freed, longest route passes at once
        drive_req(9, 5, 5, 0, 0);
        tick();
        expect_gnt("R8 all free after sweep", 9, 10);
        drive_rel(9);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule